// File: doc/BRIEF.md
# Secured Debug Engine Controller

This block sits between a scan-port command decoder and a processor core and gives a host debug control over that core. It works in one of two modes. In background mode the core runs its program and the host can only load breakpoints or ask the core to stop. In debug mode the core is held, and the host can read and write core registers and memory over a simple request/acknowledge bus, or let the core advance by one instruction at a time.

Each command is checked against a security policy before it can act. A command issued while the core is executing inside the protected system region is refused. While memory protection is on, writes to privilege registers and all accesses to system memory are refused. A refused command returns a distinct status code and never starts a bus transfer. Address breakpoints are compared against the core's instruction address on every cycle, and an enabled match halts the core.

Top module: `dbg_engine_top`

## Requirements
- R1: After a synchronous reset `cpu_halt`, `dbg_mode`, `step_done`, `bus_req` and `rsp_valid` are 0, `cmd_ready` is 1, and every breakpoint slot is disabled.
- R2: Op 2 (halt) sets `dbg_mode` and `cpu_halt`. Op 3 (resume) clears both. In background mode a register or memory access (ops 5 to 8) or a step (op 4) returns status 2 and starts no bus transfer.
- R3: Op 1 loads breakpoint slot `cmd_wdata[1:0]` with address `cmd_addr` and enable bit `cmd_wdata[15]`. When the core is running and `cpu_pc` equals an enabled slot at a clock edge, `dbg_mode` and `cpu_halt` are 1 after that edge.
- R4: A slot whose enable bit is 0 never halts the core, even when its address is reached.
- R5: In debug mode ops 5/6/7/8 (register read, register write, memory read, memory write) raise `bus_req` with `bus_mem` = 1 for memory and `bus_we` = 1 for writes. Address and data are held stable until `bus_ack`. The response carries status 0 and, for reads, `bus_rdata`.
- R6: While `prot_en` is 1, a register write to an address with bit 15 set (a privilege register) returns status 1 with no bus transfer. Privilege register reads are still served.
- R7: While `prot_en` is 1, a memory read or write at an address at or above `SYS_BASE` (0xE000) returns status 1 with no bus transfer. Memory below that address is still served.
- R8: While `in_sys_area` is 1, ops 4 to 8 return status 1 with no bus transfer and no step. This check takes precedence over the protection and mode checks.
- R9: Op 4 in debug mode drops `cpu_halt` until exactly one `cpu_retire`, then raises `cpu_halt` and `step_done` and responds with status 0. `step_done` clears when the next command is accepted.
- R10: After resume, breakpoints are ignored until the core retires its first instruction, so resuming at a breakpoint address does not halt again at once.
- R11: Any op outside 1 to 8 returns status 3. Commands without a bus transfer respond with a one-cycle `rsp_valid` pulse in the cycle after acceptance.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cmd_valid | input | 1 | Command present |
| cmd_ready | output | 1 | Engine can accept a command |
| cmd_op | input | 4 | Command opcode |
| cmd_addr | input | AW | Register, memory or breakpoint address |
| cmd_wdata | input | DW | Write data or breakpoint slot and enable |
| prot_en | input | 1 | Memory protection active |
| in_sys_area | input | 1 | Core is executing in the protected system region |
| cpu_pc | input | AW | Core instruction address |
| cpu_retire | input | 1 | Core completed one instruction this cycle |
| cpu_halt | output | 1 | Hold the core |
| dbg_mode | output | 1 | Engine is in debug mode |
| step_done | output | 1 | Last step finished |
| bus_req | output | 1 | Bus transfer request |
| bus_we | output | 1 | Transfer is a write |
| bus_mem | output | 1 | 1 = memory space, 0 = register space |
| bus_addr | output | AW | Transfer address |
| bus_wdata | output | DW | Transfer write data |
| bus_ack | input | 1 | Transfer complete |
| bus_rdata | input | DW | Read data |
| rsp_valid | output | 1 | Response pulse |
| rsp_status | output | 2 | 0 ok, 1 denied, 2 wrong mode, 3 unknown op |
| rsp_data | output | DW | Read data for the response |

## Verification
The hardest case to reach is a resume issued while the instruction address already equals an enabled breakpoint. Without the re-arm rule the core would halt again at once. The bench stalls its core model with retirement off, loads a breakpoint at the halted address and resumes. It then watches that the engine stays in background mode, releases the core, and confirms that a later breakpoint still fires at the expected address.

// File: rtl/dbg_pkg.sv
package dbg_pkg;
  localparam logic [3:0] OP_SETBP  = 4'h1;
  localparam logic [3:0] OP_HALT   = 4'h2;
  localparam logic [3:0] OP_RESUME = 4'h3;
  localparam logic [3:0] OP_STEP   = 4'h4;
  localparam logic [3:0] OP_RRD    = 4'h5;
  localparam logic [3:0] OP_RWR    = 4'h6;
  localparam logic [3:0] OP_MRD    = 4'h7;
  localparam logic [3:0] OP_MWR    = 4'h8;

  localparam logic [1:0] ST_OK    = 2'd0;
  localparam logic [1:0] ST_DENY  = 2'd1;
  localparam logic [1:0] ST_MODE  = 2'd2;
  localparam logic [1:0] ST_BADOP = 2'd3;

  typedef enum logic [1:0] {S_IDLE, S_BUS, S_STEP} eng_state_t;
endpackage

// File: rtl/dbg_bp_unit.sv
module dbg_bp_unit #(
  parameter int AW  = 16,
  parameter int NBP = 4,
  localparam int IW = (NBP > 1) ? $clog2(NBP) : 1
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          wr_en,
  input  logic [IW-1:0] wr_idx,
  input  logic [AW-1:0] wr_addr,
  input  logic          wr_enable,
  input  logic [AW-1:0] pc,
  output logic          match
);
  logic [AW-1:0]  slot_addr [NBP];
  logic [NBP-1:0] slot_en;
  logic [NBP-1:0] hit;

  genvar g;
  generate
    for (g = 0; g < NBP; g++) begin : g_slot
      always_ff @(posedge clk) begin
        if (rst) begin
          slot_en[g]   <= 1'b0;
          slot_addr[g] <= '0;
        end else if (wr_en && wr_idx == IW'(g)) begin
          slot_en[g]   <= wr_enable;
          slot_addr[g] <= wr_addr;
        end
      end
      assign hit[g] = slot_en[g] && (slot_addr[g] == pc);
    end
  endgenerate

  assign match = |hit;
endmodule

// File: rtl/dbg_policy.sv
module dbg_policy
  import dbg_pkg::*;
#(
  parameter int AW = 16,
  parameter logic [AW-1:0] SYS_BASE = 'hE000
) (
  input  logic [3:0]    op,
  input  logic [AW-1:0] addr,
  input  logic          prot_en,
  input  logic          in_sys,
  input  logic          dbg_mode,
  output logic [1:0]    verdict
);
  logic known, is_acc, is_svc, is_mem;

  always_comb begin
    known   = (op >= OP_SETBP) && (op <= OP_MWR);
    is_acc  = (op >= OP_RRD) && (op <= OP_MWR);
    is_svc  = is_acc || (op == OP_STEP);
    is_mem  = (op == OP_MRD) || (op == OP_MWR);
    if (!known)
      verdict = ST_BADOP;
    else if (is_svc && in_sys)
      verdict = ST_DENY;
    else if (prot_en && is_mem && addr >= SYS_BASE)
      verdict = ST_DENY;
    else if (prot_en && op == OP_RWR && addr[AW-1])
      verdict = ST_DENY;
    else if (is_svc && !dbg_mode)
      verdict = ST_MODE;
    else
      verdict = ST_OK;
  end
endmodule

// File: rtl/dbg_ctrl.sv
module dbg_ctrl
  import dbg_pkg::*;
#(
  parameter int AW = 16,
  parameter int DW = 16
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          cmd_valid,
  input  logic [3:0]    cmd_op,
  input  logic [AW-1:0] cmd_addr,
  input  logic [DW-1:0] cmd_wdata,
  input  logic [1:0]    verdict,
  input  logic          bp_match,
  input  logic          cpu_retire,
  input  logic          bus_ack,
  input  logic [DW-1:0] bus_rdata,
  output logic          cmd_ready,
  output logic          bp_wr,
  output logic          cpu_halt,
  output logic          dbg_mode,
  output logic          step_done,
  output logic          bus_req,
  output logic          bus_we,
  output logic          bus_mem,
  output logic [AW-1:0] bus_addr,
  output logic [DW-1:0] bus_wdata,
  output logic          rsp_valid,
  output logic [1:0]    rsp_status,
  output logic [DW-1:0] rsp_data
);
  eng_state_t state;
  logic       armed;
  logic       accept;

  assign cmd_ready = (state == S_IDLE);
  assign accept    = cmd_valid && cmd_ready;
  assign bp_wr     = accept && (cmd_op == OP_SETBP) && (verdict == ST_OK);

  always_ff @(posedge clk) begin
    if (rst) begin
      state      <= S_IDLE;
      armed      <= 1'b1;
      cpu_halt   <= 1'b0;
      dbg_mode   <= 1'b0;
      step_done  <= 1'b0;
      bus_req    <= 1'b0;
      bus_we     <= 1'b0;
      bus_mem    <= 1'b0;
      bus_addr   <= '0;
      bus_wdata  <= '0;
      rsp_valid  <= 1'b0;
      rsp_status <= ST_OK;
      rsp_data   <= '0;
    end else begin
      rsp_valid <= 1'b0;
      if (cpu_retire && !cpu_halt) armed <= 1'b1;
      case (state)
        S_IDLE: begin
          if (accept) begin
            step_done <= 1'b0;
            if (verdict != ST_OK) begin
              rsp_valid  <= 1'b1;
              rsp_status <= verdict;
              rsp_data   <= '0;
            end else begin
              case (cmd_op)
                OP_SETBP: begin
                  rsp_valid  <= 1'b1;
                  rsp_status <= ST_OK;
                  rsp_data   <= '0;
                end
                OP_HALT: begin
                  dbg_mode   <= 1'b1;
                  cpu_halt   <= 1'b1;
                  rsp_valid  <= 1'b1;
                  rsp_status <= ST_OK;
                  rsp_data   <= '0;
                end
                OP_RESUME: begin
                  if (dbg_mode) begin
                    dbg_mode <= 1'b0;
                    cpu_halt <= 1'b0;
                    armed    <= 1'b0;
                  end
                  rsp_valid  <= 1'b1;
                  rsp_status <= ST_OK;
                  rsp_data   <= '0;
                end
                OP_STEP: begin
                  cpu_halt <= 1'b0;
                  state    <= S_STEP;
                end
                default: begin
                  bus_req   <= 1'b1;
                  bus_we    <= (cmd_op == OP_RWR) || (cmd_op == OP_MWR);
                  bus_mem   <= (cmd_op == OP_MRD) || (cmd_op == OP_MWR);
                  bus_addr  <= cmd_addr;
                  bus_wdata <= cmd_wdata;
                  state     <= S_BUS;
                end
              endcase
            end
          end
        end
        S_BUS: begin
          if (bus_ack) begin
            bus_req    <= 1'b0;
            rsp_valid  <= 1'b1;
            rsp_status <= ST_OK;
            rsp_data   <= bus_rdata;
            state      <= S_IDLE;
          end
        end
        S_STEP: begin
          if (cpu_retire) begin
            cpu_halt   <= 1'b1;
            step_done  <= 1'b1;
            rsp_valid  <= 1'b1;
            rsp_status <= ST_OK;
            rsp_data   <= '0;
            state      <= S_IDLE;
          end
        end
        default: state <= S_IDLE;
      endcase
      if (!dbg_mode && armed && bp_match) begin
        dbg_mode <= 1'b1;
        cpu_halt <= 1'b1;
      end
    end
  end

  // R9: one retirement during a step ends it with the core held again
  p_step_one_r9: assert property (@(posedge clk) disable iff (rst)
    (state == S_STEP && cpu_retire) |=> (cpu_halt && step_done));

  // R5: a pending transfer keeps its request, address and direction
  p_bus_hold_r5: assert property (@(posedge clk) disable iff (rst)
    (bus_req && !bus_ack) |=> (bus_req && $stable(bus_addr) && $stable(bus_we) && $stable(bus_mem)));

  // R3: an armed, enabled match while running enters debug mode
  p_bp_halt_r3: assert property (@(posedge clk) disable iff (rst)
    (!dbg_mode && armed && bp_match) |=> (dbg_mode && cpu_halt));

  // R2: outside a step the core stays held in debug mode
  p_halt_dbg_r2: assert property (@(posedge clk) disable iff (rst)
    (dbg_mode && state != S_STEP) |-> cpu_halt);
endmodule

// File: rtl/dbg_engine_top.sv
module dbg_engine_top
  import dbg_pkg::*;
#(
  parameter int AW  = 16,
  parameter int DW  = 16,
  parameter int NBP = 4,
  parameter logic [AW-1:0] SYS_BASE = 'hE000
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          cmd_valid,
  output logic          cmd_ready,
  input  logic [3:0]    cmd_op,
  input  logic [AW-1:0] cmd_addr,
  input  logic [DW-1:0] cmd_wdata,
  input  logic          prot_en,
  input  logic          in_sys_area,
  input  logic [AW-1:0] cpu_pc,
  input  logic          cpu_retire,
  output logic          cpu_halt,
  output logic          dbg_mode,
  output logic          step_done,
  output logic          bus_req,
  output logic          bus_we,
  output logic          bus_mem,
  output logic [AW-1:0] bus_addr,
  output logic [DW-1:0] bus_wdata,
  input  logic          bus_ack,
  input  logic [DW-1:0] bus_rdata,
  output logic          rsp_valid,
  output logic [1:0]    rsp_status,
  output logic [DW-1:0] rsp_data
);
  localparam int IW = (NBP > 1) ? $clog2(NBP) : 1;

  logic [1:0] verdict;
  logic       bp_wr;
  logic       bp_match;

  dbg_policy #(.AW(AW), .SYS_BASE(SYS_BASE)) u_policy (
    .op(cmd_op), .addr(cmd_addr), .prot_en(prot_en), .in_sys(in_sys_area),
    .dbg_mode(dbg_mode), .verdict(verdict)
  );

  dbg_bp_unit #(.AW(AW), .NBP(NBP)) u_bp (
    .clk(clk), .rst(rst), .wr_en(bp_wr), .wr_idx(cmd_wdata[IW-1:0]),
    .wr_addr(cmd_addr), .wr_enable(cmd_wdata[DW-1]), .pc(cpu_pc), .match(bp_match)
  );

  dbg_ctrl #(.AW(AW), .DW(DW)) u_ctrl (
    .clk(clk), .rst(rst), .cmd_valid(cmd_valid), .cmd_op(cmd_op),
    .cmd_addr(cmd_addr), .cmd_wdata(cmd_wdata), .verdict(verdict),
    .bp_match(bp_match), .cpu_retire(cpu_retire), .bus_ack(bus_ack),
    .bus_rdata(bus_rdata), .cmd_ready(cmd_ready), .bp_wr(bp_wr),
    .cpu_halt(cpu_halt), .dbg_mode(dbg_mode), .step_done(step_done),
    .bus_req(bus_req), .bus_we(bus_we), .bus_mem(bus_mem),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .rsp_valid(rsp_valid),
    .rsp_status(rsp_status), .rsp_data(rsp_data)
  );

  // R8: no transfer starts from a command issued inside the system region
  p_sys_area_r8: assert property (@(posedge clk) disable iff (rst)
    $rose(bus_req) |-> !$past(in_sys_area));

  // R7: no system-memory transfer starts while protection was on
  p_sys_mem_r7: assert property (@(posedge clk) disable iff (rst)
    ($rose(bus_req) && bus_mem && bus_addr >= SYS_BASE) |-> !$past(prot_en));

  // R6: no privilege register write starts while protection was on
  p_priv_wr_r6: assert property (@(posedge clk) disable iff (rst)
    ($rose(bus_req) && bus_we && !bus_mem && bus_addr[AW-1]) |-> !$past(prot_en));

  // R2: transfers only start from debug mode
  p_bg_nobus_r2: assert property (@(posedge clk) disable iff (rst)
    $rose(bus_req) |-> $past(dbg_mode));
endmodule

// File: tb/tb_dbg_engine_top.sv
module tb_dbg_engine_top;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        cmd_valid = 1'b0;
  logic        cmd_ready;
  logic [3:0]  cmd_op = '0;
  logic [15:0] cmd_addr = '0;
  logic [15:0] cmd_wdata = '0;
  logic        prot_en = 1'b0;
  logic        in_sys_area = 1'b0;
  logic [15:0] cpu_pc;
  logic        cpu_retire = 1'b0;
  logic        cpu_halt, dbg_mode, step_done;
  logic        bus_req, bus_we, bus_mem;
  logic [15:0] bus_addr, bus_wdata;
  logic        bus_ack = 1'b0;
  logic [15:0] bus_rdata = '0;
  logic        rsp_valid;
  logic [1:0]  rsp_status;
  logic [15:0] rsp_data;

  int n_tests = 0, n_fail = 0, n_bus = 0, n_ret = 0, cyc = 0, dly = 0;
  logic cpu_en = 1'b0;
  logic req_d = 1'b0;
  logic [15:0] regs [256];
  logic [15:0] mem  [256];

  always #5 clk = ~clk;

  dbg_engine_top dut (.*);

  // core model: retires one instruction per cycle when released
  always @(posedge clk) begin
    if (rst) cpu_pc <= 16'h0100;
    else if (cpu_retire) begin
      cpu_pc <= cpu_pc + 16'd1;
      n_ret  <= n_ret + 1;
    end
    req_d <= bus_req;
    if (bus_req && !req_d) n_bus <= n_bus + 1;
  end
  always @(negedge clk) cpu_retire <= !cpu_halt && cpu_en && !rst;

  // bus responder with two cycles of wait
  always @(negedge clk) begin
    if (bus_ack) bus_ack <= 1'b0;
    else if (bus_req) begin
      dly = dly + 1;
      if (dly == 2) begin
        dly = 0;
        bus_ack <= 1'b1;
        if (bus_we) begin
          if (bus_mem) mem[bus_addr[7:0]] = bus_wdata;
          else regs[bus_addr[7:0]] = bus_wdata;
          bus_rdata <= '0;
        end else
          bus_rdata <= bus_mem ? mem[bus_addr[7:0]] : regs[bus_addr[7:0]];
      end
    end
  end

  always @(posedge clk) begin
    cyc <= cyc + 1;
    if (cyc == 100000) begin
      n_fail = n_fail + 1;
      $display("FAIL watchdog: run did not finish (actual timeout, expected completion)");
      $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  end

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_tests = n_tests + 1;
    if (act !== exp) begin
      n_fail = n_fail + 1;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  task automatic do_cmd(input logic [3:0] op, input logic [15:0] a, input logic [15:0] d,
                        output logic [1:0] st, output logic [15:0] rd);
    while (!cmd_ready) @(negedge clk);
    cmd_valid = 1'b1; cmd_op = op; cmd_addr = a; cmd_wdata = d;
    @(negedge clk);
    cmd_valid = 1'b0;
    for (int i = 0; i < 40; i++) begin
      if (rsp_valid) break;
      @(negedge clk);
    end
    st = rsp_status;
    rd = rsp_data;
  endtask

  task automatic t_reset;
    check("R1 cpu_halt", cpu_halt, 0);
    check("R1 dbg_mode", dbg_mode, 0);
    check("R1 step_done", step_done, 0);
    check("R1 bus_req", bus_req, 0);
    check("R1 rsp_valid", rsp_valid, 0);
    check("R1 cmd_ready", cmd_ready, 1);
  endtask

  task automatic t_background;
    logic [1:0] st; logic [15:0] rd; int b0;
    b0 = n_bus;
    do_cmd(4'h5, 16'h0001, 0, st, rd);
    check("R2 bg reg read status", st, 2);
    do_cmd(4'h4, 0, 0, st, rd);
    check("R2 bg step status", st, 2);
    check("R2 bg no bus", n_bus - b0, 0);
    do_cmd(4'hF, 0, 0, st, rd);
    check("R11 bad op F", st, 3);
    do_cmd(4'h0, 0, 0, st, rd);
    check("R11 bad op 0", st, 3);
  endtask

  task automatic t_breakpoint;
    logic [1:0] st; logic [15:0] rd;
    do_cmd(4'h1, 16'h0120, 16'h0001, st, rd);   // slot 1, disabled
    check("R4 setbp status", st, 0);
    do_cmd(4'h1, 16'h0140, 16'h8002, st, rd);   // slot 2, enabled
    check("R3 setbp status", st, 0);
    cpu_en = 1'b1;
    for (int i = 0; i < 200; i++) begin
      if (dbg_mode) break;
      @(negedge clk);
    end
    check("R3 dbg_mode after hit", dbg_mode, 1);
    check("R3 cpu_halt after hit", cpu_halt, 1);
    check("R4 halted past disabled slot, pc", cpu_pc, 16'h0141);
  endtask

  task automatic t_rearm;
    logic [1:0] st; logic [15:0] rd;
    cpu_en = 1'b0;
    do_cmd(4'h1, 16'h0141, 16'h8000, st, rd);
    do_cmd(4'h3, 0, 0, st, rd);
    check("R2 resume status", st, 0);
    repeat (5) @(negedge clk);
    check("R10 no re-hit at resume address", dbg_mode, 0);
    check("R10 core released", cpu_halt, 0);
    do_cmd(4'h1, 16'h0145, 16'h8003, st, rd);
    cpu_en = 1'b1;
    for (int i = 0; i < 50; i++) begin
      if (dbg_mode) break;
      @(negedge clk);
    end
    check("R10 later breakpoint fires", dbg_mode, 1);
    check("R10 halt pc", cpu_pc, 16'h0146);
  endtask

  task automatic t_step;
    logic [1:0] st; logic [15:0] rd; int r0;
    r0 = n_ret;
    do_cmd(4'h4, 0, 0, st, rd);
    check("R9 step status", st, 0);
    @(negedge clk);
    check("R9 one retire", n_ret - r0, 1);
    check("R9 halt back", cpu_halt, 1);
    check("R9 step_done", step_done, 1);
    check("R9 pc", cpu_pc, 16'h0147);
    in_sys_area = 1'b1;
    r0 = n_ret;
    do_cmd(4'h4, 0, 0, st, rd);
    check("R8 step denied in system area", st, 1);
    check("R9 step_done cleared by next command", step_done, 0);
    repeat (3) @(negedge clk);
    check("R8 no retire on denied step", n_ret - r0, 0);
    in_sys_area = 1'b0;
  endtask

  task automatic t_access;
    logic [1:0] st; logic [15:0] rd; int b0;
    do_cmd(4'h6, 16'h0007, 16'hBEEF, st, rd);
    check("R5 reg write status", st, 0);
    do_cmd(4'h5, 16'h0007, 0, st, rd);
    check("R5 reg read data", rd, 16'hBEEF);
    do_cmd(4'h8, 16'h0030, 16'h1234, st, rd);
    do_cmd(4'h7, 16'h0030, 0, st, rd);
    check("R5 mem read data", rd, 16'h1234);
    check("R5 mem read status", st, 0);
  endtask

  task automatic t_protect;
    logic [1:0] st; logic [15:0] rd; int b0;
    do_cmd(4'h6, 16'h8003, 16'h1111, st, rd);
    do_cmd(4'h8, 16'hE010, 16'h3333, st, rd);
    do_cmd(4'h8, 16'h0020, 16'h5555, st, rd);
    prot_en = 1'b1;
    b0 = n_bus;
    do_cmd(4'h6, 16'h8003, 16'h2222, st, rd);
    check("R6 priv write denied", st, 1);
    do_cmd(4'h8, 16'hE010, 16'h4444, st, rd);
    check("R7 sys mem write denied", st, 1);
    do_cmd(4'h7, 16'hE010, 0, st, rd);
    check("R7 sys mem read denied", st, 1);
    check("R6 R7 no bus on denial", n_bus - b0, 0);
    do_cmd(4'h5, 16'h8003, 0, st, rd);
    check("R6 priv read allowed", rd, 16'h1111);
    do_cmd(4'h7, 16'h0020, 0, st, rd);
    check("R7 low mem allowed", rd, 16'h5555);
    prot_en = 1'b0;
    do_cmd(4'h7, 16'hE010, 0, st, rd);
    check("R7 sys mem unchanged", rd, 16'h3333);
  endtask

  task automatic t_sysarea;
    logic [1:0] st; logic [15:0] rd; int b0;
    in_sys_area = 1'b1;
    b0 = n_bus;
    do_cmd(4'h5, 16'h0007, 0, st, rd);
    check("R8 reg read denied", st, 1);
    do_cmd(4'h8, 16'h0030, 16'h9999, st, rd);
    check("R8 mem write denied", st, 1);
    check("R8 no bus", n_bus - b0, 0);
    in_sys_area = 1'b0;
    do_cmd(4'h7, 16'h0030, 0, st, rd);
    check("R8 mem unchanged", rd, 16'h1234);
    cpu_en = 1'b0;
    do_cmd(4'h3, 0, 0, st, rd);
    in_sys_area = 1'b1;
    do_cmd(4'h5, 16'h0007, 0, st, rd);
    check("R8 precedence over mode error", st, 1);
    in_sys_area = 1'b0;
    do_cmd(4'h2, 0, 0, st, rd);
    check("R2 halt command mode", dbg_mode, 1);
    check("R2 halt command halt", cpu_halt, 1);
  endtask

  initial begin
    for (int i = 0; i < 256; i++) begin regs[i] = '0; mem[i] = '0; end
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    t_reset();
    t_background();
    t_breakpoint();
    t_rearm();
    t_step();
    t_access();
    t_protect();
    t_sysarea();
    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule